// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Table

This block is a small ternary content-addressable table that resolves a 32-bit IPv4 destination address to a next-hop code by longest-prefix match. Every entry stores a key, a care mask and a next-hop value. A mask bit of 1 makes the matching key bit significant, and a mask bit of 0 makes it a wildcard. Together they give each stored bit three states: 0, 1 or don't care.

All entries are compared against the address in parallel. When more than one entry matches, the one at the lowest index wins. Software that keeps longer prefixes at lower indices therefore gets the most specific route. An entry with an all-zero mask matches every address, so when it is placed in the last slot it serves as the default route.

A write port loads or deletes one entry per cycle. The lookup port accepts one address per cycle and returns a registered result one clock later: a hit flag, the winning index and its next hop.

Top module: `tcam_lpm`

## Requirements
- R1: An entry matches an address when it is valid and ((address XOR key) AND mask) is zero. A mask bit of 1 means the key bit must match, and a mask bit of 0 means that bit is ignored. A /L prefix uses a mask whose top L bits are set.
- R2: When several entries match, the result reports the matching entry with the lowest index, together with that entry's next hop.
- R3: Invalid entries never match. When no entry matches, the response has rsp_hit=0, rsp_idx=0 and rsp_nh=0.
- R4: An entry with mask 0 (0.0.0.0/0) matches every address. When it sits at the highest index it is returned only for addresses that no other entry covers.
- R5: rsp_valid is high exactly in the cycle after a cycle with lk_req high. Lookups may be issued on back-to-back cycles, and each one gets its own result.
- R6: A write and a lookup in the same cycle: the lookup sees the table as it was before the write. A lookup in the next cycle sees the written entry.
- R7: After reset every entry is invalid and rsp_valid, rsp_hit, rsp_idx and rsp_nh are 0.
- R8: In cycles without a lookup, rsp_hit, rsp_idx and rsp_nh keep the values of the last lookup.
- R9: A write with wr_valid=0 deletes the entry at wr_idx. Later lookups fall through to the next matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | clog2(DEPTH) | Entry index to write |
| wr_valid | input | 1 | Valid bit stored with the entry (0 deletes it) |
| wr_key | input | AW | Key bits of the entry |
| wr_mask | input | AW | Care mask, 1 = compare bit |
| wr_nh | input | NHW | Next-hop value of the entry |
| lk_req | input | 1 | Start a lookup this cycle |
| lk_addr | input | AW | Destination address to look up |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_idx | output | clog2(DEPTH) | Index of the winning entry |
| rsp_nh | output | NHW | Next hop of the winning entry |

## Verification
The assertions check the response timing (R5), the zeroed fields on a miss (R3) and the hold of the result fields in idle cycles (R8) on every cycle. They also check that a fully matching entry written in one cycle is found, at its own index or a lower one, by a lookup in the next cycle (R6, R2). The correct winner among overlapping prefixes, wildcard bits inside the key, the default route, deletion, the old-table view of a lookup that coincides with a write, and the reset contents can only be shown by the bench's scenarios, which compare each result against an expected index and next hop.

// File: rtl/tcam_lpm.sv
module tcam_lpm #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int NHW   = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_key,
  input  logic [AW-1:0]  wr_mask,
  input  logic [NHW-1:0] wr_nh,
  input  logic           lk_req,
  input  logic [AW-1:0]  lk_addr,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [IW-1:0]  rsp_idx,
  output logic [NHW-1:0] rsp_nh
);

  logic [AW-1:0]  key_q  [DEPTH];
  logic [AW-1:0]  mask_q [DEPTH];
  logic [NHW-1:0] nh_q   [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic           any_hit;
  logic [IW-1:0]  win_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx]  <= wr_key;
      mask_q[wr_idx] <= wr_mask;
      nh_q[wr_idx]   <= wr_nh;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (((lk_addr ^ key_q[g]) & mask_q[g]) == '0);
  end

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_nh    <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit <= any_hit;
        rsp_idx <= win_idx;
        rsp_nh  <= any_hit ? nh_q[win_idx] : '0;
      end
    end
  end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int NHW   = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [IW-1:0]  wr_idx,
  input logic           wr_valid,
  input logic [AW-1:0]  wr_key,
  input logic [AW-1:0]  wr_mask,
  input logic [NHW-1:0] wr_nh,
  input logic           lk_req,
  input logic [AW-1:0]  lk_addr,
  input logic           rsp_valid,
  input logic           rsp_hit,
  input logic [IW-1:0]  rsp_idx,
  input logic [NHW-1:0] rsp_nh
);

  logic          last_wr;
  logic [IW-1:0] last_idx;
  logic [AW-1:0] last_key;
  logic [AW-1:0] last_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr   <= 1'b0;
      last_idx  <= '0;
      last_key  <= '0;
      last_mask <= '0;
    end else begin
      last_wr   <= wr_en && wr_valid;
      last_idx  <= wr_idx;
      last_key  <= wr_key;
      last_mask <= wr_mask;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid); // R5
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid); // R5
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_nh == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ($stable(rsp_hit) && $stable(rsp_idx) && $stable(rsp_nh))); // R8
  AST_NEW_ENTRY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && lk_req && (((lk_addr ^ last_key) & last_mask) == '0))
      |=> (rsp_hit && rsp_idx <= $past(last_idx))); // R6

endmodule

bind tcam_lpm tcam_lpm_chk #(.DEPTH(DEPTH), .AW(AW), .NHW(NHW)) u_chk (.*);

// File: tb/tcam_lpm_test.sv
module tcam_lpm_test;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int NHW = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_key = '0;
  logic [AW-1:0] wr_mask = '0;
  logic [NHW-1:0] wr_nh = '0;
  logic lk_req = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic rsp_valid, rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic [NHW-1:0] rsp_nh;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tcam_lpm #(.DEPTH(DEPTH), .AW(AW), .NHW(NHW)) uut (.*);

  function automatic logic [AW-1:0] pmask(int len);
    return (len == 0) ? '0 : ~((AW'(1) << (AW - len)) - AW'(1));
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_entry(int idx, logic v, logic [AW-1:0] key, int len, logic [NHW-1:0] nh);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v;
    wr_key = key; wr_mask = pmask(len); wr_nh = nh;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup_chk(string req, logic [AW-1:0] addr, logic hit, int idx, logic [NHW-1:0] nh);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = addr;
    @(negedge clk);
    lk_req = 1'b0;
    chk(req, "valid", 32'(rsp_valid), 1);
    chk(req, "hit", 32'(rsp_hit), 32'(hit));
    chk(req, "idx", 32'(rsp_idx), 32'(idx));
    chk(req, "nh", 32'(rsp_nh), 32'(nh));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7", "valid", 32'(rsp_valid), 0);
    chk("R7", "hit", 32'(rsp_hit), 0);
    chk("R7", "idx", 32'(rsp_idx), 0);
    chk("R7", "nh", 32'(rsp_nh), 0);
    lookup_chk("R7", 32'h0A01_0205, 0, 0, 0);
  endtask

  task automatic t_prefixes();
    write_entry(0, 1, 32'h0A01_0200, 24, 8'h11);
    write_entry(1, 1, 32'h0A01_0000, 16, 8'h22);
    write_entry(2, 1, 32'h0A00_0000, 8, 8'h33);
    lookup_chk("R3", 32'h0B00_0001, 0, 0, 0);
    lookup_chk("R2", 32'h0A01_0205, 1, 0, 8'h11);
    lookup_chk("R2", 32'h0A01_0909, 1, 1, 8'h22);
    lookup_chk("R1", 32'h0A09_0909, 1, 2, 8'h33);
  endtask

  task automatic t_default();
    write_entry(15, 1, 32'h0, 0, 8'hFF);
    lookup_chk("R4", 32'h0B00_0001, 1, 15, 8'hFF);
    lookup_chk("R4", 32'hFFFF_FFFF, 1, 15, 8'hFF);
    lookup_chk("R4", 32'h0A01_0205, 1, 0, 8'h11);
  endtask

  task automatic t_wildcard();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3; wr_valid = 1'b1;
    wr_key = 32'hC0A8_FF05; wr_mask = 32'hFFFF_00FF; wr_nh = 8'h44;
    @(negedge clk);
    wr_en = 1'b0;
    lookup_chk("R1", 32'hC0A8_4D05, 1, 3, 8'h44);
    lookup_chk("R1", 32'hC0A8_4D06, 1, 15, 8'hFF);
  endtask

  task automatic t_delete();
    write_entry(0, 0, 32'h0A01_0200, 24, 8'h11);
    lookup_chk("R9", 32'h0A01_0205, 1, 1, 8'h22);
    write_entry(1, 0, 32'h0A01_0000, 16, 8'h22);
    write_entry(2, 0, 32'h0A00_0000, 8, 8'h33);
    lookup_chk("R3", 32'h0A01_0205, 1, 15, 8'hFF);
    write_entry(1, 1, 32'h0A01_0000, 16, 8'h22);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 0; wr_valid = 1'b1;
    wr_key = 32'h0A01_0205; wr_mask = pmask(32); wr_nh = 8'h66;
    lk_req = 1'b1; lk_addr = 32'h0A01_0205;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6", "old idx", 32'(rsp_idx), 1);
    chk("R6", "old nh", 32'(rsp_nh), 32'h22);
    @(negedge clk);
    lk_req = 1'b0;
    chk("R6", "new idx", 32'(rsp_idx), 0);
    chk("R6", "new nh", 32'(rsp_nh), 32'h66);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    lk_req = 1'b1; lk_addr = 32'h0A01_0205;
    @(negedge clk);
    lk_addr = 32'h0A01_7777;
    chk("R5", "first idx", 32'(rsp_idx), 0);
    @(negedge clk);
    lk_addr = 32'h7F00_0001;
    chk("R5", "second valid", 32'(rsp_valid), 1);
    chk("R5", "second idx", 32'(rsp_idx), 1);
    @(negedge clk);
    lk_req = 1'b0;
    chk("R5", "third idx", 32'(rsp_idx), 15);
    @(negedge clk);
    chk("R5", "valid drops", 32'(rsp_valid), 0);
  endtask

  task automatic t_hold();
    lookup_chk("R8", 32'h0A01_0999, 1, 1, 8'h22);
    write_entry(1, 0, 32'h0A01_0000, 16, 8'h22);
    repeat (3) @(negedge clk);
    chk("R8", "valid", 32'(rsp_valid), 0);
    chk("R8", "hit", 32'(rsp_hit), 1);
    chk("R8", "idx", 32'(rsp_idx), 1);
    chk("R8", "nh", 32'(rsp_nh), 32'h22);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prefixes();
    t_default();
    t_wildcard();
    t_delete();
    t_same_cycle();
    t_back_to_back();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule